// File: doc/BRIEF.md
# Processor Reset Sequencer

This block sits between the board-level reset pin of a small processor core and the core itself. The raw, active-high reset pin is brought into the processor clock domain through a chain of flip-flops. Once synchronized, the reset level is measured. The core is halted as soon as the synchronized reset goes high, and it stays halted for as long as the reset is held. After the reset falls, a fixed initialization interval runs. The core is then released with its fetch address preset to the power-on start location.

A reset pulse that is not long enough is reported on a one-cycle error strobe and does not start an initialization. The core stays halted until a proper reset arrives. A separate gate, `nmi_allowed`, keeps non-maskable interrupt recognition blocked from the moment the reset is seen until a set number of clocks after the reset is released. While `power_up_done` is low, the whole block is held in its cleared state, so a reset release that happens before power-up has finished has no effect.

Top module: `core_reset_seq`

## Requirements
- R1: The reset pin reaches the sequencer only through a synchronizer of `SYNC_STAGES` (2) flops. Counting posedges from the first edge that samples the pin high as edge 0, `core_halt` rises after edge 2 when the core was running.
- R2: While `power_up_done` is low, the outputs are `core_halt`=1, `core_start`=0, `reset_too_short`=0, `nmi_allowed`=0 and `start_addr`=0, and edges on `rst_pin` have no effect. Dropping `power_up_done` returns the block to this state on the next clock.
- R3: Once the synchronized reset is high, `core_halt` is 1, and it stays 1 for every cycle the reset remains high.
- R4: If the pin is sampled high on `MIN_HIGH` (4) or fewer posedges, then `reset_too_short` is 1 for exactly one cycle, after posedge N+2 where N is the number of high samples. In this case no `core_start` follows and `core_halt` stays 1.
- R5: If the pin is sampled high on N > `MIN_HIGH` posedges, then `core_start` is a single-cycle pulse after posedge N+9. This is `INIT_CYCLES` (7) cycles after the release is seen at posedge N+2.
- R6: In the cycle in which `core_start` is 1, `start_addr` equals `START_ADDR` (20'hFFFF0).
- R7: `core_halt` falls in the same cycle as `core_start` and stays 0 until the next synchronized reset.
- R8: `nmi_allowed` is 0 from the cycle `core_halt` rises until after posedge N+4, which is the second clock after the release is seen. It is 1 from then on while the core is initializing or running.
- R9: If the reset rises again during the initialization interval, no `core_start` is produced for that interval. A new reset sequence begins instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_pin | input | 1 | Raw asynchronous reset pin, active high |
| power_up_done | input | 1 | Power-up finished; low holds the block cleared |
| core_halt | output | 1 | Core must stay idle |
| core_start | output | 1 | One-cycle release pulse for the core |
| start_addr | output | ADDR_W | Fetch address handed to the core at release |
| reset_too_short | output | 1 | One-cycle strobe for a reset pulse below the minimum width |
| nmi_allowed | output | 1 | Non-maskable interrupt recognition permitted |

## Verification
The bench uses the default parameters: two synchronizer stages, a 4-cycle minimum width, a 7-cycle initialization and a 2-cycle NMI mask. These small values let a sweep of pulse widths from 1 to 8 cycles cross the width threshold on both sides, starting both from a halted core and from a running one. Every cycle of each sequence is compared against an expected value that is computed from the pulse length. The bench also re-asserts reset in the middle of initialization and toggles the pin while power-up is still pending.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    RSQ_WAIT = 2'd0,
    RSQ_HELD = 2'd1,
    RSQ_INIT = 2'd2,
    RSQ_RUN  = 2'd3
  } rsq_state_t;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES < 2) begin : g_bad_depth
      $error("rsq_sync needs at least two stages");
    end
  endgenerate

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (clr) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rsq_width.sv
module rsq_width #(
  parameter int MIN_HIGH = 4
) (
  input  logic clk,
  input  logic clr,
  input  logic level,
  output logic long_ok
);
  localparam int SAT   = MIN_HIGH + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  logic [CNT_W-1:0] cnt;

  // saturating count of consecutive synchronized-high cycles
  always_ff @(posedge clk) begin
    if (clr || !level)           cnt <= '0;
    else if (cnt != CNT_W'(SAT)) cnt <= cnt + 1'b1;
  end

  assign long_ok = (cnt > CNT_W'(MIN_HIGH));

  assert_width_sat_R4: assert property (@(posedge clk) disable iff (clr)
    cnt <= CNT_W'(SAT));
endmodule

// File: rtl/rsq_tick.sv
module rsq_tick #(
  parameter int LIMIT = 7
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  output logic at_last
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr || !run)     cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == LAST);

  assert_tick_range_R5: assert property (@(posedge clk) disable iff (clr)
    cnt <= LAST);
endmodule

// File: rtl/core_reset_seq.sv
module core_reset_seq
  import rsq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 4,
  parameter int INIT_CYCLES = 7,
  parameter int NMI_HOLD    = 2,
  parameter int ADDR_W      = 20,
  parameter logic [ADDR_W-1:0] START_ADDR = 'hFFFF0
) (
  input  logic              clk,
  input  logic              rst_pin,
  input  logic              power_up_done,
  output logic              core_halt,
  output logic              core_start,
  output logic [ADDR_W-1:0] start_addr,
  output logic              reset_too_short,
  output logic              nmi_allowed
);
  logic clr;
  logic rst_s;
  logic long_ok;
  logic init_done;
  logic nmi_ready;

  rsq_state_t state_q, state_d;

  assign clr = ~power_up_done;

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .clr (clr),
    .din (rst_pin),
    .dout(rst_s)
  );

  rsq_width #(.MIN_HIGH(MIN_HIGH)) u_width (
    .clk    (clk),
    .clr    (clr),
    .level  (rst_s),
    .long_ok(long_ok)
  );

  rsq_tick #(.LIMIT(INIT_CYCLES)) u_init (
    .clk    (clk),
    .clr    (clr),
    .run    (state_q == RSQ_INIT),
    .at_last(init_done)
  );

  rsq_tick #(.LIMIT(NMI_HOLD)) u_nmi (
    .clk    (clk),
    .clr    (clr),
    .run    ((state_q == RSQ_INIT) || (state_q == RSQ_RUN)),
    .at_last(nmi_ready)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RSQ_WAIT: if (rst_s) state_d = RSQ_HELD;
      RSQ_HELD: if (!rst_s) state_d = long_ok ? RSQ_INIT : RSQ_WAIT;
      RSQ_INIT: begin
        if (rst_s)          state_d = RSQ_HELD;
        else if (init_done) state_d = RSQ_RUN;
      end
      RSQ_RUN:  if (rst_s) state_d = RSQ_HELD;
      default:  state_d = RSQ_WAIT;
    endcase
  end

  logic post_now, post_next;
  assign post_now  = (state_q == RSQ_INIT) || (state_q == RSQ_RUN);
  assign post_next = (state_d == RSQ_INIT) || (state_d == RSQ_RUN);

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q         <= RSQ_WAIT;
      core_halt       <= 1'b1;
      core_start      <= 1'b0;
      start_addr      <= '0;
      reset_too_short <= 1'b0;
      nmi_allowed     <= 1'b0;
    end else begin
      state_q         <= state_d;
      core_halt       <= (state_d != RSQ_RUN);
      core_start      <= (state_q == RSQ_INIT) && (state_d == RSQ_RUN);
      reset_too_short <= (state_q == RSQ_HELD) && !rst_s && !long_ok;
      nmi_allowed     <= post_now && post_next && nmi_ready;
      if ((state_q == RSQ_INIT) && (state_d == RSQ_RUN))
        start_addr <= START_ADDR;
    end
  end

  assert_halt_hold_R3: assert property (@(posedge clk) disable iff (clr)
    rst_s |=> core_halt);

  assert_short_once_R4: assert property (@(posedge clk) disable iff (clr)
    reset_too_short |=> !reset_too_short);

  assert_short_no_start_R4: assert property (@(posedge clk) disable iff (clr)
    reset_too_short |-> (core_halt && !core_start));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (clr)
    core_start |=> !core_start);

  assert_start_addr_R6: assert property (@(posedge clk) disable iff (clr)
    core_start |-> (start_addr == START_ADDR));

  assert_halt_release_R7: assert property (@(posedge clk) disable iff (clr)
    $fell(core_halt) |-> core_start);

  assert_nmi_mask_R8: assert property (@(posedge clk) disable iff (clr)
    (state_q == RSQ_HELD) |-> !nmi_allowed);

  assert_abort_R9: assert property (@(posedge clk) disable iff (clr)
    ((state_q == RSQ_INIT) && rst_s) |=> (core_halt && !core_start));
endmodule

// File: tb/sim_core_reset_seq.sv
module sim_core_reset_seq;
  localparam int MIN_HIGH = 4;

  logic        clk = 1'b0;
  logic        rst_pin = 1'b0;
  logic        power_up_done = 1'b0;
  logic        core_halt, core_start, reset_too_short, nmi_allowed;
  logic [19:0] start_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  core_reset_seq u0 (
    .clk            (clk),
    .rst_pin        (rst_pin),
    .power_up_done  (power_up_done),
    .core_halt      (core_halt),
    .core_start     (core_start),
    .start_addr     (start_addr),
    .reset_too_short(reset_too_short),
    .nmi_allowed    (nmi_allowed)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Raise the pin for n posedges; check each cycle up to index last.
  // ph / pn: halt and nmi levels before the reset is seen.
  task automatic run_pulse(int n, bit ph, bit pn, int last);
    bit valid = (n > MIN_HIGH);
    bit eh, en, es, et;
    rst_pin = 1'b1;
    for (int a = 0; a <= last; a++) begin
      @(negedge clk);
      if (a < 2) begin
        eh = ph; en = pn; es = 0; et = 0;
      end else if (a <= n + 1) begin
        eh = 1; en = 0; es = 0; et = 0;
      end else if (valid) begin
        et = 0; es = (a == n + 9); eh = (a < n + 9); en = (a >= n + 4);
      end else begin
        et = (a == n + 2); eh = 1; en = 0; es = 0;
      end
      if (a < 2) chk("R1 halt before sync", core_halt, eh);
      else if (a <= n + 1) chk("R3 halt while held", core_halt, eh);
      else chk("R7 halt after release", core_halt, eh);
      chk(valid ? "R5 start pulse" : "R4 no start on short", core_start, es);
      chk("R4 too_short strobe", reset_too_short, et);
      chk("R8 nmi gate", nmi_allowed, en);
      if (es) chk("R6 start address", start_addr, 20'hFFFF0);
      if (a == n - 1) rst_pin = 1'b0;
    end
  endtask

  initial begin
    int lens [9] = '{3, 6, 2, 5, 4, 7, 1, 8, 5};
    bit running = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset halt", core_halt, 1);
    chk("R2 reset start", core_start, 0);
    chk("R2 reset short", reset_too_short, 0);
    chk("R2 reset nmi", nmi_allowed, 0);
    chk("R2 reset addr", start_addr, 0);

    // pin activity before power-up completes is ignored
    rst_pin = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (i == 7) rst_pin = 1'b0;
      chk("R2 ignored halt", core_halt, 1);
      chk("R2 ignored start", core_start, 0);
      chk("R2 ignored short", reset_too_short, 0);
      chk("R2 ignored nmi", nmi_allowed, 0);
    end
    power_up_done = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 still halted after power-up", core_halt, 1);
    chk("R2 nmi blocked after power-up", nmi_allowed, 0);

    foreach (lens[i]) begin
      run_pulse(lens[i], !running, running, lens[i] + 11);
      running = (lens[i] > MIN_HIGH);
    end

    // R9: reset re-raised during initialization
    run_pulse(6, 1'b0, 1'b1, 6 + 5);
    run_pulse(6, 1'b1, 1'b1, 6 + 11);

    // R2: dropping power-up clears the block
    @(negedge clk);
    power_up_done = 1'b0;
    @(negedge clk);
    chk("R2 power drop halt", core_halt, 1);
    chk("R2 power drop nmi", nmi_allowed, 0);
    chk("R2 power drop addr", start_addr, 0);
    power_up_done = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      finish_run();
    end
  end
endmodule